// File: doc/BRIEF.md
# PCI Configuration Space Target Decoder

This block is the configuration-space front end of a single-function PCI target. At the address phase (the first clock edge at which FRAME# is seen low after having been high) it samples the address/data bus, the command/byte-enable lines and IDSEL. It recognises type 0 configuration reads and writes and extracts a dword register index. It then claims the cycle with DEVSEL# using medium decode timing, serves exactly one data phase, and disconnects any burst.

The register file behind it holds a small known map:

| Index | Contents |
|---|---|
| 0 | A read-only identity word |
| 1 | One writable command/status dword. Only the bits set in a write mask are kept; the other bits read as zero. |
| 2 | A read-only class word |
| all others | Reserved. They read as zero and ignore writes, with no error response. |

Reads always return all four bytes. Writes update only the byte lanes whose active-low enables are asserted.

Top module: `cfg_tgt`

## Requirements
- R1: A cycle is claimed only when, at the address phase, IDSEL is high, address bits [1:0] are 00, and C/BE#[3:0] is 1010 (configuration read) or 1011 (configuration write). Otherwise DEVSEL# stays high and no register changes.
- R2: Address bits [7:2] at the address phase select the dword register index (0 to 63).
- R3: DEVSEL# goes low after the second clock edge following the address-phase edge. This is medium decode timing.
- R4: TRDY# goes low one clock after DEVSEL#. The data phase completes at the first edge where both TRDY# and IRDY# are low, and TRDY# is deasserted at that edge.
- R5: During a read data phase, the block drives all 32 bits (ad_oe_o high) with the addressed register, whatever the byte enables are.
- R6: A write updates only the byte lanes whose C/BE# bit is 0 in the data phase (lane n is bits 8n+7:8n). With C/BE# = 1111 the write changes nothing.
- R7: Reserved locations behave as follows, with no error signalling. Every index other than 0, 1 and 2 reads as zero. Bits of index 1 outside the mask 32'h0F3C_0147 read as zero. Writes to reserved indices and reserved bits, and to the read-only words at index 0 (value 32'h1A2B_3C4D) and index 2 (value 32'h0200_0001), are discarded. Index 1 resets to zero.
- R8: If FRAME# is still low during the first data phase, STOP# is asserted together with TRDY#. Only that first phase is transferred; nothing is written after it.
- R9: DEVSEL# and STOP# are released on the edge at which both IRDY# and FRAME# are sampled high after the final phase. TRDY# and STOP# are never low while DEVSEL# is high.
- R10: During and just after reset, DEVSEL#, TRDY# and STOP# are high and ad_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | 32 | Address/data bus as seen by the target |
| cbe_n_i | input | 4 | Command (address phase) / byte enables (data phase), active low |
| idsel_i | input | 1 | Configuration select |
| frame_n_i | input | 1 | Cycle frame, active low |
| irdy_n_i | input | 1 | Master ready, active low |
| ad_o | output | 32 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| devsel_n_o | output | 1 | Device select claim, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Disconnect request, active low |

## Verification
The schedule is counted from the negative edge at which the monitor first sees FRAME# low, since that level is taken at the next rising edge.

- DEVSEL# is due low at the third later negative edge, and TRDY# at the fourth.
- Read data and the STOP# level are due in that TRDY# window.
- Release is due two rising edges after IRDY# and FRAME# both return high.

A driver task pushes the expected read word, disconnect flag and requirement into a queue before it starts each claimed cycle. A monitor, sampling on negative edges, pops one item exactly when TRDY# and IRDY# are both low. It compares data, STOP#, and the DEVSEL#/TRDY# offsets against the fixed counts 3 and 4. Writes and ignored accesses are judged through later reads of the same index.

// File: rtl/cfg_tgt_pkg.sv
package cfg_tgt_pkg;

    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int IDX_W     = 6;
    localparam int ADDR_LO_W = IDX_W + 2;

    localparam logic [3:0] CMD_CFG_READ  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_MEDIUM,
        ST_CLAIM,
        ST_DATA,
        ST_HOLD
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e         state;
        logic               frame_prev;
        logic               devsel;
        logic               trdy;
        logic               stop;
        logic               oe;
        logic               wr;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  rdata;
    } tgt_regs_t;

endpackage

// File: rtl/cfg_tgt_decode.sv
module cfg_tgt_decode
    import cfg_tgt_pkg::*;
(
    input  logic [ADDR_LO_W-1:0] addr_lo,
    input  logic [3:0]           cmd_n,
    input  logic                 sel,
    output logic                 hit,
    output logic                 is_wr,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        is_wr = (cmd_n == CMD_CFG_WRITE);
        hit   = sel && (addr_lo[1:0] == 2'b00)
                    && (is_wr || (cmd_n == CMD_CFG_READ));
        idx   = addr_lo[ADDR_LO_W-1:2];
    end

endmodule

// File: rtl/cfg_tgt_regfile.sv
module cfg_tgt_regfile
    import cfg_tgt_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_WORD    = 32'h1A2B_3C4D,
    parameter logic [DATA_W-1:0] CLASS_WORD = 32'h0200_0001,
    parameter logic [DATA_W-1:0] CMD_WMASK  = 32'h0F3C_0147,
    parameter int                ID_IDX     = 0,
    parameter int                CMD_IDX    = 1,
    parameter int                CLASS_IDX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cmd_d, cmd_q;
    logic              cmd_sel;

    assign cmd_sel = wr_en && (idx == IDX_W'(CMD_IDX));

    // Per-lane next value: enabled lanes take the masked write data.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cmd_d[g*8 +: 8] = (cmd_sel && wr_be[g])
                                 ? (wr_data[g*8 +: 8] & CMD_WMASK[g*8 +: 8])
                                 : cmd_q[g*8 +: 8];

        // R6: a disabled lane keeps its value across a write
        p_lane_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_be[g]) |=> $stable(cmd_q[g*8 +: 8]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        case (idx)
            IDX_W'(ID_IDX):    rd_data = ID_WORD;
            IDX_W'(CMD_IDX):   rd_data = cmd_q;
            IDX_W'(CLASS_IDX): rd_data = CLASS_WORD;
            default:           rd_data = '0;
        endcase
    end

    // R7: bits outside the writable mask never become set
    p_reserved_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q & ~CMD_WMASK) == '0);

endmodule

// File: rtl/cfg_tgt.sv
module cfg_tgt
    import cfg_tgt_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h1A2B_3C4D,
    parameter logic [31:0] CLASS_WORD = 32'h0200_0001,
    parameter logic [31:0] CMD_WMASK  = 32'h0F3C_0147
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad_i,
    input  logic [3:0]  cbe_n_i,
    input  logic        idsel_i,
    input  logic        frame_n_i,
    input  logic        irdy_n_i,
    output logic [31:0] ad_o,
    output logic        ad_oe_o,
    output logic        devsel_n_o,
    output logic        trdy_n_o,
    output logic        stop_n_o
);

    localparam tgt_regs_t REGS_RESET = '{
        state:      ST_IDLE,
        frame_prev: 1'b1,
        devsel:     1'b0,
        trdy:       1'b0,
        stop:       1'b0,
        oe:         1'b0,
        wr:         1'b0,
        idx:        '0,
        rdata:      '0
    };

    tgt_regs_t         regs_d, regs_q;
    logic              dec_hit, dec_wr;
    logic [IDX_W-1:0]  dec_idx;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_wr_en;

    cfg_tgt_decode u_decode (
        .addr_lo (ad_i[ADDR_LO_W-1:0]),
        .cmd_n   (cbe_n_i),
        .sel     (idsel_i),
        .hit     (dec_hit),
        .is_wr   (dec_wr),
        .idx     (dec_idx)
    );

    assign rf_wr_en = (regs_q.state == ST_DATA) && !irdy_n_i && regs_q.wr;

    cfg_tgt_regfile #(
        .ID_WORD    (ID_WORD),
        .CLASS_WORD (CLASS_WORD),
        .CMD_WMASK  (CMD_WMASK)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (regs_q.idx),
        .wr_en   (rf_wr_en),
        .wr_be   (~cbe_n_i),
        .wr_data (ad_i),
        .rd_data (rf_rdata)
    );

    always_comb begin
        regs_d            = regs_q;
        regs_d.frame_prev = frame_n_i;
        case (regs_q.state)
            ST_IDLE: begin
                if (!frame_n_i && regs_q.frame_prev && dec_hit) begin
                    regs_d.state = ST_DECODE;
                    regs_d.idx   = dec_idx;
                    regs_d.wr    = dec_wr;
                end
            end
            ST_DECODE: regs_d.state = ST_MEDIUM;
            ST_MEDIUM: begin
                regs_d.state  = ST_CLAIM;
                regs_d.devsel = 1'b1;
            end
            ST_CLAIM: begin
                regs_d.state = ST_DATA;
                regs_d.trdy  = 1'b1;
                regs_d.oe    = !regs_q.wr;
                regs_d.rdata = rf_rdata;
                regs_d.stop  = !frame_n_i;
            end
            ST_DATA: begin
                regs_d.stop = regs_q.stop || !frame_n_i;
                if (!irdy_n_i) begin
                    regs_d.state = ST_HOLD;
                    regs_d.trdy  = 1'b0;
                    regs_d.oe    = 1'b0;
                end
            end
            ST_HOLD: begin
                if (irdy_n_i && frame_n_i) begin
                    regs_d.state  = ST_IDLE;
                    regs_d.devsel = 1'b0;
                    regs_d.stop   = 1'b0;
                end
            end
            default: regs_d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    assign ad_o       = regs_q.rdata;
    assign ad_oe_o    = regs_q.oe;
    assign devsel_n_o = !regs_q.devsel;
    assign trdy_n_o   = !regs_q.trdy;
    assign stop_n_o   = !regs_q.stop;

    // R1: a claim follows only a valid type 0 configuration address phase
    p_claim_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n_o) |-> ($past(idsel_i, 3) && ($past(ad_i[1:0], 3) == 2'b00)
            && (($past(cbe_n_i, 3) == CMD_CFG_READ) || ($past(cbe_n_i, 3) == CMD_CFG_WRITE))));

    // R3: medium timing, frame was low at the address-phase edge
    p_medium_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n_o) |-> !$past(frame_n_i, 3));

    // R4: TRDY# falls exactly one clock after DEVSEL#
    p_trdy_after_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n_o) |-> (!$past(devsel_n_o) && $past(devsel_n_o, 2)));

    // R5: read data phase drives the bus
    p_read_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && !regs_q.wr) |-> ad_oe_o);

    // R8: a burst sees STOP# with its first data phase
    p_burst_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && !frame_n_i) |-> !stop_n_o);

    // R8: only one data phase is completed
    p_single_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && !irdy_n_i) |=> trdy_n_o);

    // R9: release waits for the master to go idle
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n_o) |-> ($past(irdy_n_i) && $past(frame_n_i)));

    // R9: no TRDY#/STOP# without DEVSEL#
    p_no_orphan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        devsel_n_o |-> (trdy_n_o && stop_n_o));

endmodule

// File: tb/cfg_tgt_tb.sv
module cfg_tgt_tb;

    localparam logic [31:0] ID_W   = 32'h1A2B_3C4D;
    localparam logic [31:0] CLS_W  = 32'h0200_0001;
    localparam logic [31:0] MASK_W = 32'h0F3C_0147;
    localparam logic [3:0]  C_RD   = 4'b1010;
    localparam logic [3:0]  C_WR   = 4'b1011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_n_i = 4'hF;
    logic        idsel_i = 1'b0;
    logic        frame_n_i = 1'b1;
    logic        irdy_n_i = 1'b1;
    logic [31:0] ad_o;
    logic        ad_oe_o, devsel_n_o, trdy_n_o, stop_n_o;

    always #5 clk = ~clk;

    cfg_tgt u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad_i       (ad_i),
        .cbe_n_i    (cbe_n_i),
        .idsel_i    (idsel_i),
        .frame_n_i  (frame_n_i),
        .irdy_n_i   (irdy_n_i),
        .ad_o       (ad_o),
        .ad_oe_o    (ad_oe_o),
        .devsel_n_o (devsel_n_o),
        .trdy_n_o   (trdy_n_o),
        .stop_n_o   (stop_n_o)
    );

    typedef struct {
        logic        rd;
        logic [31:0] data;
        logic        stop;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] cmd_m = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: counts negedges from the frame start, pops on completion
    int   mon_cnt = 0;
    int   mon_dcnt = -1;
    logic mon_fprev = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!frame_n_i && mon_fprev) begin
                mon_cnt  = 0;
                mon_dcnt = -1;
            end else begin
                mon_cnt++;
            end
            mon_fprev = frame_n_i;
            if (!devsel_n_o && mon_dcnt < 0) mon_dcnt = mon_cnt;
            if (!trdy_n_o && !irdy_n_i) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected data phase", 32'(mon_cnt), 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(mon_dcnt == 3, {e.req, " R3 devsel offset"}, 32'(mon_dcnt), 32'd3);
                    chk(mon_cnt == 4, {e.req, " R4 trdy offset"}, 32'(mon_cnt), 32'd4);
                    chk(stop_n_o == !e.stop, {e.req, " R8 stop"}, 32'(stop_n_o), 32'(!e.stop));
                    if (e.rd) begin
                        chk(ad_oe_o == 1'b1, {e.req, " R5 oe"}, 32'(ad_oe_o), 32'd1);
                        chk(ad_o == e.data, {e.req, " R5 data"}, ad_o, e.data);
                    end
                end
            end
        end
    end

    // Driver: one configuration cycle, pushing its expectation first
    task automatic cfg_cycle(input logic [3:0] cmd, input logic [7:0] addr_lo,
                             input logic sel, input logic [3:0] be_n,
                             input logic [31:0] wdata, input logic burst,
                             input logic claim, input logic [31:0] exp,
                             input string req);
        if (claim) sb_q.push_back('{rd: (cmd == C_RD), data: exp, stop: burst, req: req});
        @(posedge clk); #2;
        frame_n_i = 1'b0;
        ad_i      = {24'hA5C3E1, addr_lo};
        cbe_n_i   = cmd;
        idsel_i   = sel;
        @(posedge clk); #2;
        frame_n_i = !burst;
        irdy_n_i  = 1'b0;
        cbe_n_i   = be_n;
        ad_i      = wdata;
        idsel_i   = 1'b0;
        if (claim) begin
            do @(negedge clk); while (trdy_n_o);
            @(posedge clk); #2;
            if (burst) begin
                frame_n_i = 1'b1;
                ad_i      = ~wdata;
                cbe_n_i   = 4'h0;
                @(posedge clk); #2;
            end
            irdy_n_i = 1'b1;
            cbe_n_i  = 4'hF;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(devsel_n_o && trdy_n_o && stop_n_o, {req, " R9 release"},
                {29'd0, devsel_n_o, trdy_n_o, stop_n_o}, 32'd7);
        end else begin
            bit seen = 1'b0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (!devsel_n_o) seen = 1'b1;
            end
            chk(!seen, {req, " R1 not claimed"}, 32'(seen), 32'd0);
            @(posedge clk); #2;
            frame_n_i = 1'b1;
            irdy_n_i  = 1'b1;
            cbe_n_i   = 4'hF;
            repeat (2) @(posedge clk);
        end
    endtask

    task automatic rd(input int idx, input logic [31:0] exp, input string req);
        cfg_cycle(C_RD, 8'(idx << 2), 1'b1, 4'h0, 32'h0, 1'b0, 1'b1, exp, req);
    endtask

    task automatic wr(input int idx, input logic [3:0] be_n, input logic [31:0] d,
                      input string req);
        cfg_cycle(C_WR, 8'(idx << 2), 1'b1, be_n, d, 1'b0, 1'b1, 32'h0, req);
        if (idx == 1) begin
            for (int g = 0; g < 4; g++)
                if (!be_n[g]) cmd_m[g*8 +: 8] = d[g*8 +: 8] & MASK_W[g*8 +: 8];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(devsel_n_o && trdy_n_o && stop_n_o && !ad_oe_o, "R10 in reset",
            {28'd0, devsel_n_o, trdy_n_o, stop_n_o, ad_oe_o}, 32'hE);
        rst_n = 1'b1;
        @(negedge clk);
        chk(devsel_n_o && trdy_n_o && stop_n_o && !ad_oe_o, "R10 after reset",
            {28'd0, devsel_n_o, trdy_n_o, stop_n_o, ad_oe_o}, 32'hE);

        rd(0, ID_W, "R2 id read");
        rd(2, CLS_W, "R2 class read");
        rd(1, 32'h0, "R7 cmd reset");
        rd(5, 32'h0, "R7 reserved read");
        rd(63, 32'h0, "R7 reserved top index");
        wr(5, 4'h0, 32'hFFFF_FFFF, "R7 reserved write");
        rd(5, 32'h0, "R7 reserved after write");
        wr(0, 4'h0, 32'h0, "R7 id write");
        rd(0, ID_W, "R7 id unchanged");
        wr(2, 4'h0, 32'hFFFF_FFFF, "R7 class write");
        rd(2, CLS_W, "R7 class unchanged");

        wr(1, 4'h0, 32'hFFFF_FFFF, "R6 full write");
        rd(1, cmd_m, "R6 full write readback");
        wr(1, 4'hF, 32'h0, "R6 no-op write");
        rd(1, cmd_m, "R6 no-op readback");

        for (int b = 0; b < 16; b++) begin
            wr(1, 4'h0, 32'hFFFF_FFFF, "R6 preset");
            wr(1, 4'(b), 32'h0, "R6 lane write");
            rd(1, cmd_m, "R6 lane mask readback");
        end

        // Reads return all bytes regardless of byte enables (R5)
        cfg_cycle(C_RD, 8'h00, 1'b1, 4'hE, 32'h0, 1'b0, 1'b1, ID_W, "R5 partial-be read");

        // Not claimed: IDSEL low, wrong command, type 1 form (R1)
        cfg_cycle(C_RD, 8'h00, 1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R1 idsel low");
        cfg_cycle(4'b0110, 8'h00, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R1 memory cmd");
        cfg_cycle(C_RD, 8'h01, 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R1 type1 form");
        cfg_cycle(C_WR, 8'h04, 1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R1 idsel low write");
        rd(1, cmd_m, "R1 cmd unchanged");

        // Bursts are disconnected after the first phase (R8)
        cfg_cycle(C_RD, 8'h08, 1'b1, 4'h0, 32'h0, 1'b1, 1'b1, CLS_W, "R8 burst read");
        cfg_cycle(C_WR, 8'h04, 1'b1, 4'h0, 32'h0A14_0102, 1'b1, 1'b1, 32'h0, "R8 burst write");
        cmd_m = 32'h0A14_0102 & MASK_W;
        rd(1, cmd_m, "R8 first phase only");

        repeat (4) @(posedge clk);
        chk(sb_q.size() == 0, "R4 all phases completed", 32'(sb_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule